// File: doc/BRIEF.md
# Multi-Channel Timer with Output Initialization

The block is a general-purpose timer with one up-counter, a power-of-two prescaler and a small set of channels. Each channel works either as an input capture unit or as an output compare unit. Software programs it through a simple write port and reads it back through a combinational read port. The register map has these entries:

- Control (clock source and prescale), at 0.
- Counter, at 1.
- Start value, at 2.
- Modulo value, at 3.
- Status flags, at 4.
- Per-channel configuration and value. Channel n uses 8+2n for its configuration and 9+2n for its value.

The counter runs from the start value up to the modulo value and then reloads. The clock source can be the system clock or the rising edge of a synchronized external tick input. A write of any data to the counter address reinitializes the block. The counter takes the start value, the prescaler phase restarts, and every channel not in output compare mode drives its programmed initial level. Compare channels keep their present output. The pin output enables are asserted only while a clock source is selected, so configuration can be finished with the pins released. Software then reinitializes the counter and finally selects a clock.

Top module: `mtimer_top`

## Requirements
- R1: After reset the counter reads 0, the control register reads 0 (clock stopped, prescale 0), all status flags read 0, every channel configuration reads 0 (input capture, edge select 00, initial level 0), and all pin outputs and output enables are 0.
- R2: Control bits [1:0] select the clock. 00 stops the counter and prescaler, 01 advances on every system clock, and 10 or 11 advance once per rising edge of the external tick input after two-stage synchronization.
- R3: Control bits [4:2] hold PS, and the counter advances once every 2^PS selected clock events.
- R4: On an advance from the modulo value the counter reloads the start value and sets the sticky overflow flag (status bit 0). Otherwise it increments by one.
- R5: Status flags are cleared by writing 1 to their bit. Writing 0 leaves them unchanged.
- R6: Any write to the counter address loads the start value, whatever the data, and restarts the prescaler phase.
- R7: A counter-address write sets every input capture channel's output to its initial level (configuration bit 3) and leaves output compare channels' outputs unchanged.
- R8: A pin output enable is 1 only while the clock select is non-zero, the channel is in output compare mode (configuration bit 0 = 1) and its edge select (configuration bits [2:1]) is non-zero.
- R9: An output compare channel acts on a counter advance taken while the counter equals its compare value. It toggles (edge select 01), clears (10) or sets (11) its output, and it sets its status flag (bit 2+n).
- R10: An input capture channel latches the counter into its value register on a synchronized rising edge (edge select 01), a falling edge (10) or both (11), and it sets its status flag. Edges not selected are ignored.
- R11: A synchronized rising edge of the fault input sets the fault flag (status bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | CW | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | CW | Read data (combinational) |
| ext_tick_i | input | 1 | External clock-source tick |
| cap_i | input | NCH | Capture inputs |
| fault_i | input | 1 | Fault input |
| pin_o | output | NCH | Channel output levels |
| oe_o | output | NCH | Channel pin output enables |
| irq_ovf_o | output | 1 | Overflow flag |
| irq_ch_o | output | NCH | Channel event flags |
| irq_fault_o | output | 1 | Fault flag |

## Verification
A wrong counter or prescaler state shows up in the counter read one advance later. It also shows as a compare toggle landing on the wrong cycle, which appears on the pin in the cycle after the advance where the counter equals the compare value. A stale channel output after reinitialization is visible on the pins straight after the counter write. A lost or stuck flag shows in the status register on the next read. Capture faults appear in the channel value register three cycles after the input edge, once synchronization is done.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int unsigned AW = 4;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_SYS  = 2'b01,
    SEL_EXT  = 2'b10,
    SEL_EXT2 = 2'b11
  } clk_sel_e;

  // bit 3 init level, bits 2:1 edge/level select, bit 0 compare mode
  typedef struct packed {
    logic       init;
    logic [1:0] els;
    logic       cmp;
  } ch_cfg_t;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_CNT   = 4'd1;
  localparam logic [AW-1:0] A_START = 4'd2;
  localparam logic [AW-1:0] A_MOD   = 4'd3;
  localparam logic [AW-1:0] A_STAT  = 4'd4;
  localparam int unsigned   CH_BASE = 8;

  function automatic logic [AW-1:0] ch_cfg_addr(input int idx);
    return AW'(CH_BASE + 2 * idx);
  endfunction

  function automatic logic [AW-1:0] ch_val_addr(input int idx);
    return AW'(CH_BASE + 2 * idx + 1);
  endfunction
endpackage

// File: rtl/mtimer_edge.sv
module mtimer_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/mtimer_presc.sv
module mtimer_presc #(
  parameter int unsigned PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           clr_i,
  input  logic [PSW-1:0] ps_i,
  output logic           tick_o
);
  localparam int unsigned PCW = (1 << PSW) - 1;

  logic [PCW-1:0] pre_q;
  logic [PCW-1:0] mask;

  assign mask   = PCW'((1 << ps_i) - 1);
  assign tick_o = en_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else if (en_i)   pre_q <= pre_q + 1'b1;
  end

  // R6
  presc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));

  // R2
  presc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          reinit_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] mod_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = tick_i && !reinit_i && (cnt_q == mod_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (reinit_i) cnt_q <= start_i;
    else if (tick_i)   cnt_q <= (cnt_q == mod_i) ? start_i : cnt_q + 1'b1;
  end

  // R2
  cnt_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reinit_i) |=> $stable(cnt_q));

  // R4
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !reinit_i && cnt_q == mod_i) |=> (cnt_q == $past(start_i)));

  // R6
  cnt_reinit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (cnt_q == $past(start_i)));
endmodule

// File: rtl/mtimer_chan.sv
module mtimer_chan
  import mtimer_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ch_cfg_t       cfg_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          reinit_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          cv_wr_i,
  input  logic [CW-1:0] cv_wdata_i,
  output logic [CW-1:0] cv_o,
  output logic          out_o,
  output logic          oe_o,
  output logic          evt_o
);
  logic [CW-1:0] cv_q;
  logic          out_q;
  logic          match, cap;

  assign match = cfg_i.cmp && tick_i && (cfg_i.els != 2'b00) && (cnt_i == cv_q);
  assign cap   = !cfg_i.cmp && ((cfg_i.els[0] && rise_i) || (cfg_i.els[1] && fall_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cv_q <= '0;
    else if (cap)     cv_q <= cnt_i;
    else if (cv_wr_i) cv_q <= cv_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else if (reinit_i && !cfg_i.cmp) out_q <= cfg_i.init;
    else if (match) begin
      unique case (cfg_i.els)
        2'b01:   out_q <= ~out_q;
        2'b10:   out_q <= 1'b0;
        2'b11:   out_q <= 1'b1;
        default: out_q <= out_q;
      endcase
    end
  end

  assign cv_o  = cv_q;
  assign out_o = out_q;
  assign oe_o  = run_i && cfg_i.cmp && (cfg_i.els != 2'b00);
  assign evt_o = match | cap;

  // R7
  ch_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reinit_i && !cfg_i.cmp) |=> (out_o == $past(cfg_i.init)));

  // R10
  ch_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.cmp && cfg_i.els[0] && rise_i) |=> (cv_o == $past(cnt_i)));

  // R9
  ch_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.cmp && cfg_i.els == 2'b11 && tick_i && cnt_i == cv_o) |=> out_o);
endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
  import mtimer_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned CW  = 16,
  parameter int unsigned PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [CW-1:0]  wr_data_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [CW-1:0]  rd_data_o,
  input  logic           ext_tick_i,
  input  logic [NCH-1:0] cap_i,
  input  logic           fault_i,
  output logic [NCH-1:0] pin_o,
  output logic [NCH-1:0] oe_o,
  output logic           irq_ovf_o,
  output logic [NCH-1:0] irq_ch_o,
  output logic           irq_fault_o
);
  localparam int unsigned CTRLW = 2 + PSW;
  localparam int unsigned STATW = 2 + NCH;

  clk_sel_e       sel_q;
  logic [PSW-1:0] ps_q;
  logic [CW-1:0]  start_q, mod_q, cnt;
  logic           ovf_q, flt_q;
  logic [NCH-1:0] chf;
  ch_cfg_t        cfg_vec [NCH];
  logic [CW-1:0]  cv_vec  [NCH];

  logic run, presc_en, tick, wrap, reinit, stat_wr;
  logic ext_rise, flt_rise;
  logic [NCH-1:0] cap_rise, cap_fall;
  logic ext_fall_unused, flt_fall_unused, wdata_unused;

  assign wdata_unused = ^wr_data_i;

  assign reinit  = wr_en_i && (wr_addr_i == A_CNT);
  assign stat_wr = wr_en_i && (wr_addr_i == A_STAT);
  assign run     = (sel_q != SEL_OFF);

  always_comb begin
    unique case (sel_q)
      SEL_SYS:          presc_en = 1'b1;
      SEL_EXT, SEL_EXT2: presc_en = ext_rise;
      default:          presc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= SEL_OFF;
      ps_q    <= '0;
      start_q <= '0;
      mod_q   <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_CTRL) begin
        sel_q <= clk_sel_e'(wr_data_i[1:0]);
        ps_q  <= wr_data_i[CTRLW-1:2];
      end
      if (wr_addr_i == A_START) start_q <= wr_data_i;
      if (wr_addr_i == A_MOD)   mod_q   <= wr_data_i;
    end
  end

  // Sticky flags: a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      ovf_q <= wrap     | (ovf_q & ~(stat_wr & wr_data_i[0]));
      flt_q <= flt_rise | (flt_q & ~(stat_wr & wr_data_i[1]));
    end
  end

  mtimer_edge #(.W(1)) u_ext_sync (
    .clk_i, .rst_ni, .d_i(ext_tick_i), .rise_o(ext_rise), .fall_o(ext_fall_unused)
  );

  mtimer_edge #(.W(1)) u_flt_sync (
    .clk_i, .rst_ni, .d_i(fault_i), .rise_o(flt_rise), .fall_o(flt_fall_unused)
  );

  mtimer_edge #(.W(NCH)) u_cap_sync (
    .clk_i, .rst_ni, .d_i(cap_i), .rise_o(cap_rise), .fall_o(cap_fall)
  );

  mtimer_presc #(.PSW(PSW)) u_presc (
    .clk_i, .rst_ni, .en_i(presc_en), .clr_i(reinit), .ps_i(ps_q), .tick_o(tick)
  );

  mtimer_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .reinit_i(reinit),
    .start_i(start_q), .mod_i(mod_q), .cnt_o(cnt), .wrap_o(wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic    cfg_wr, cv_wr, evt, flag_q;
    ch_cfg_t cfg_q;

    assign cfg_wr = wr_en_i && (wr_addr_i == ch_cfg_addr(g));
    assign cv_wr  = wr_en_i && (wr_addr_i == ch_val_addr(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q  <= '0;
        flag_q <= 1'b0;
      end else begin
        if (cfg_wr) cfg_q <= ch_cfg_t'(wr_data_i[3:0]);
        flag_q <= evt | (flag_q & ~(stat_wr & wr_data_i[2+g]));
      end
    end

    assign cfg_vec[g] = cfg_q;
    assign chf[g]     = flag_q;

    mtimer_chan #(.CW(CW)) u_chan (
      .clk_i, .rst_ni,
      .cfg_i(cfg_q), .run_i(run), .tick_i(tick), .cnt_i(cnt), .reinit_i(reinit),
      .rise_i(cap_rise[g]), .fall_i(cap_fall[g]),
      .cv_wr_i(cv_wr), .cv_wdata_i(wr_data_i),
      .cv_o(cv_vec[g]), .out_o(pin_o[g]), .oe_o(oe_o[g]), .evt_o(evt)
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CTRL)  rd_data_o[CTRLW-1:0] = {ps_q, sel_q};
    if (rd_addr_i == A_CNT)   rd_data_o = cnt;
    if (rd_addr_i == A_START) rd_data_o = start_q;
    if (rd_addr_i == A_MOD)   rd_data_o = mod_q;
    if (rd_addr_i == A_STAT)  rd_data_o[STATW-1:0] = {chf, flt_q, ovf_q};
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr_i == ch_cfg_addr(i)) rd_data_o[3:0] = cfg_vec[i];
      if (rd_addr_i == ch_val_addr(i)) rd_data_o = cv_vec[i];
    end
  end

  assign irq_ovf_o   = ovf_q;
  assign irq_fault_o = flt_q;
  assign irq_ch_o    = chf;

  // R8
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == SEL_OFF) |-> (oe_o == '0));

  // R5
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ovf_o && !(stat_wr && wr_data_i[0])) |=> irq_ovf_o);

  // R11
  flt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_fault_o && !(stat_wr && wr_data_i[1])) |=> irq_fault_o);
endmodule

// File: tb/test_mtimer_top.sv
module test_mtimer_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NCH = 2;
  localparam int unsigned CW  = 16;

  typedef struct {
    int          kind;   // 0 register read, 1 pins, 2 output enables
    logic [3:0]  addr;
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic ext_tick = 1'b0;
  logic [NCH-1:0] cap = '0;
  logic fault = 1'b0;
  logic [NCH-1:0] pin, oe, irq_ch;
  logic irq_ovf, irq_fault;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mtimer_top #(.NCH(NCH), .CW(CW), .PSW(3)) i_mtimer_top (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ext_tick_i(ext_tick), .cap_i(cap), .fault_i(fault),
    .pin_o(pin), .oe_o(oe), .irq_ovf_o(irq_ovf), .irq_ch_o(irq_ch), .irq_fault_o(irq_fault)
  );

  // Monitor: pops one expected item per cycle, compares away from the edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        1:       act = 16'(pin);
        2:       act = 16'(oe);
        default: act = rd_data;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h", it.tag, it.kind, it.addr, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic chk(input int kind, input logic [3:0] a, input logic [15:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    rd_addr = a;
    it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk(0, 4'd1, 16'd0, "R1 counter");
    chk(0, 4'd0, 16'd0, "R1 control");
    chk(0, 4'd4, 16'd0, "R1 status");
    chk(0, 4'd8, 16'd0, "R1 ch0 cfg");
    chk(0, 4'd10, 16'd0, "R1 ch1 cfg");
    chk(1, 4'd0, 16'd0, "R1 pins");
    chk(2, 4'd0, 16'd0, "R1 oe");

    // setup: start 5, modulo 9, ch0 compare toggle at 7, ch1 capture rising init 1
    wr(4'd2, 16'd5);
    wr(4'd3, 16'd9);
    wr(4'd8, 16'h3);
    wr(4'd9, 16'd7);
    wr(4'd10, 16'hA);
    wr(4'd1, 16'hBEEF);
    chk(0, 4'd1, 16'd5, "R6 counter loads start");
    chk(1, 4'd0, 16'b10, "R7 capture ch init level");
    chk(2, 4'd0, 16'd0, "R8 oe off while stopped");

    // R4 R9 run on system clock, prescale 0
    wr(4'd0, 16'd1);
    chk(0, 4'd1, 16'd6, "R4 count up");
    chk(1, 4'd0, 16'b10, "R9 before match");
    chk(1, 4'd0, 16'b11, "R9 toggle on match");
    chk(0, 4'd4, 16'd4, "R9 ch0 flag");
    chk(2, 4'd0, 16'b01, "R8 oe compare ch");
    chk(0, 4'd4, 16'd5, "R4 overflow flag");
    chk(0, 4'd1, 16'd7, "R4 reload start");

    // R5 write-one-to-clear
    wr(4'd0, 16'd0);
    wr(4'd4, 16'd0);
    chk(0, 4'd4, 16'd5, "R5 zero write ignored");
    wr(4'd4, 16'd1);
    chk(0, 4'd4, 16'd4, "R5 clear ovf");
    wr(4'd4, 16'd4);
    chk(0, 4'd4, 16'd0, "R5 clear ch0");

    // R2 stopped counter holds
    wr(4'd1, 16'd0);
    idle(5);
    chk(0, 4'd1, 16'd5, "R2 stopped holds");
    chk(2, 4'd0, 16'd0, "R8 oe off after stop");

    // R3 prescale 2 -> one advance per 4 cycles
    wr(4'd0, 16'd9);
    chk(0, 4'd1, 16'd5, "R3 no advance yet");
    idle(2);
    chk(0, 4'd1, 16'd6, "R3 first advance");
    idle(3);
    chk(0, 4'd1, 16'd7, "R3 second advance");
    wr(4'd0, 16'd0);

    // R9 clear mode, compare at 6
    wr(4'd8, 16'h5);
    wr(4'd9, 16'd6);
    wr(4'd1, 16'd0);
    wr(4'd0, 16'd1);
    idle(2);
    chk(1, 4'd0, 16'b10, "R9 clear on match");
    idle(4);
    chk(1, 4'd0, 16'b10, "R9 clear repeated");
    wr(4'd0, 16'd0);

    // R9 set mode
    wr(4'd8, 16'h7);
    wr(4'd1, 16'd0);
    wr(4'd0, 16'd1);
    idle(2);
    chk(1, 4'd0, 16'b11, "R9 set on match");
    idle(4);
    chk(1, 4'd0, 16'b11, "R9 set repeated");
    wr(4'd0, 16'd0);

    // R7 reinit keeps compare output, forces capture init
    wr(4'd1, 16'h1234);
    chk(1, 4'd0, 16'b11, "R7 compare ch kept");
    wr(4'd10, 16'h2);
    wr(4'd1, 16'h0);
    chk(1, 4'd0, 16'b01, "R7 capture ch init 0");

    // R10 capture
    wr(4'd4, 16'hFFFF);
    cap[1] = 1'b1;
    idle(4);
    chk(0, 4'd11, 16'd5, "R10 rising capture");
    chk(0, 4'd4, 16'd8, "R10 capture flag");
    wr(4'd4, 16'hFFFF);
    cap[1] = 1'b0;
    idle(4);
    chk(0, 4'd4, 16'd0, "R10 falling ignored");
    wr(4'd2, 16'd8);
    wr(4'd1, 16'd0);
    wr(4'd10, 16'h4);
    cap[1] = 1'b1;
    idle(4);
    chk(0, 4'd11, 16'd5, "R10 rising ignored");
    cap[1] = 1'b0;
    idle(4);
    chk(0, 4'd11, 16'd8, "R10 falling capture");
    chk(0, 4'd4, 16'd8, "R10 falling flag");

    // R2 external tick source
    wr(4'd4, 16'hFFFF);
    wr(4'd0, 16'd2);
    idle(5);
    chk(0, 4'd1, 16'd8, "R2 no ext edge");
    ext_tick = 1'b1; idle(3); ext_tick = 1'b0; idle(3);
    chk(0, 4'd1, 16'd9, "R2 ext edge advance");
    ext_tick = 1'b1; idle(3); ext_tick = 1'b0; idle(3);
    chk(0, 4'd1, 16'd8, "R4 ext wrap");
    chk(0, 4'd4, 16'd1, "R4 ext overflow flag");
    chk(2, 4'd0, 16'b01, "R8 oe with ext source");

    // R11 fault
    wr(4'd0, 16'd0);
    wr(4'd4, 16'hFFFF);
    fault = 1'b1;
    idle(4);
    chk(0, 4'd4, 16'd2, "R11 fault flag");
    wr(4'd4, 16'd2);
    chk(0, 4'd4, 16'd0, "R11 fault cleared");
    fault = 1'b0;

    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule